// File: doc/BRIEF.md
# Quench Persistence Detector

This block watches one superconducting-coil channel and decides whether a quench is under way. It receives compensated voltage samples, one every 10 ms, as a signed word with a valid strobe. A quench is declared only when the magnitude of the voltage stays above a programmable threshold for a programmable number of consecutive samples. The alarm output is fail-safe and normally high: it goes low on a quench and stays low until it is cleared.

A separate watchdog drives the alarm low when the sample stream stops. An inhibit input keeps the alarm high while a channel is deliberately taken out of service. A typical setting is a threshold near 100 mV in sample units and a holding time of 100 to 300 samples, which is 1 s to 3 s. The holding time is clamped so that a quench is never declared later than 3 s after the voltage starts to exceed the threshold.

Top module: `quench_persist_det`

## Requirements
- R1: While reset is asserted, and after it is released, `alarm_n` is high and the run counter is zero.
- R2: A sample counts as over-threshold only when its two's-complement magnitude is strictly greater than `thresh`. Positive and negative values are treated the same, and -32768 has magnitude 32768.
- R3: A valid sample whose magnitude is at or below `thresh` sets the run counter back to zero. A full new run of over-threshold samples is then needed.
- R4: `alarm_n` goes low at the clock edge that captures the over-threshold sample completing the run. It is seen low from the next cycle on. Cycles without `smp_valid` neither add to the run nor break it.
- R5: The effective holding time is `hold_len`, except that 0 is treated as 1 and any value above 300 is treated as 300.
- R6: Once low, `alarm_n` stays low until `alarm_clr` is sampled high. The clear also zeroes the run counter and the sample watchdog. If a clear and a completing sample arrive in the same cycle, the clear wins.
- R7: While `inhibit` is sampled high, the run counter is held at zero, no new alarm is latched and `alarm_n` is high. An alarm latched before the inhibit shows again once the inhibit is released.
- R8: If no valid sample arrives for 3 consecutive periods of `PERIOD_CYC` clock cycles, `alarm_n` goes low at the edge that completes that quiet time. It stays latched until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Strobe marking a new sample |
| smp_data | input | 16 | Signed compensated voltage sample |
| thresh | input | 16 | Unsigned magnitude threshold |
| hold_len | input | 9 | Holding time in samples |
| inhibit | input | 1 | Masks detection and forces the alarm high |
| alarm_clr | input | 1 | Clears the latched alarm, run counter and watchdog |
| alarm_n | output | 1 | Fail-safe alarm, low on quench or sample loss |

## Verification
Every result of this block is registered. A sample, clear or inhibit sampled at an edge therefore shows on `alarm_n` in the cycle that follows that edge. The only longer result is the watchdog: its alarm is due at the 30th edge after the last sample when `PERIOD_CYC` is 10. The bench drives one cycle of stimulus per step on the falling edge. After the next rising edge it queues the alarm level expected for that cycle, and a monitor compares the queued level at the following falling edge. In this way each expectation is tied to the exact edge at which the requirement says the output changes.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int SMP_W_DEF      = 16;
  localparam int HOLD_W_DEF     = 9;
  localparam int MAX_HOLD_DEF   = 300;
  localparam int PERIOD_CYC_DEF = 500000;
  localparam int MISS_DEF       = 3;

  typedef struct packed {
    logic quench;
    logic stale;
  } qpd_flag_t;
endpackage

// File: rtl/qpd_mag_cmp.sv
module qpd_mag_cmp #(
  parameter int SMP_W = 16
) (
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic        [SMP_W-1:0] thr_i,
  output logic                    over_o
);
  localparam int MW = SMP_W + 1;

  logic [MW-1:0] ext;
  logic [MW-1:0] mag;

  always_comb begin
    ext    = {smp_i[SMP_W-1], smp_i};
    mag    = smp_i[SMP_W-1] ? (~ext + MW'(1)) : ext;
    over_o = mag > {1'b0, thr_i};
  end
endmodule

// File: rtl/qpd_persist.sv
module qpd_persist #(
  parameter int HOLD_W   = 9,
  parameter int MAX_HOLD = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              over_i,
  input  logic              inhibit_i,
  input  logic              clr_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic              quench_d_o,
  output logic              quench_q_o
);
  localparam int RW = HOLD_W + 1;

  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [HOLD_W-1:0] hold_eff;
  logic [RW-1:0]     run_nx;
  logic              reach, hit, cnt_en;
  logic              quench_q, quench_d;

  always_comb begin
    if (hold_len_i == '0)
      hold_eff = HOLD_W'(1);
    else if (hold_len_i > HOLD_W'(MAX_HOLD))
      hold_eff = HOLD_W'(MAX_HOLD);
    else
      hold_eff = hold_len_i;

    run_nx = {1'b0, cnt_q} + RW'(1);
    reach  = run_nx >= {1'b0, hold_eff};
    cnt_en = clr_i | inhibit_i | valid_i;
    hit    = valid_i & over_i & reach & ~clr_i & ~inhibit_i;

    cnt_d = cnt_q;
    if (clr_i || inhibit_i)
      cnt_d = '0;
    else if (valid_i)
      cnt_d = over_i ? (reach ? hold_eff : run_nx[HOLD_W-1:0]) : '0;

    quench_d = quench_q;
    if (clr_i)
      quench_d = 1'b0;
    else if (hit)
      quench_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      quench_q <= 1'b0;
    end else begin
      if (cnt_en)
        cnt_q <= cnt_d;
      quench_q <= quench_d;
    end
  end

  assign quench_d_o = quench_d;
  assign quench_q_o = quench_q;

  p_below_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !over_i) |=> (cnt_q == '0));

  p_trip_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quench_q) |-> ($past(run_nx) >= {1'b0, $past(hold_eff)}));

  p_latch_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quench_q && !clr_i) |=> quench_q);

  p_inhibit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> (cnt_q == '0));
endmodule

// File: rtl/qpd_stale_wd.sv
module qpd_stale_wd #(
  parameter int PERIOD_CYC = 500000,
  parameter int MISS       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic inhibit_i,
  input  logic clr_i,
  output logic stale_d_o,
  output logic stale_q_o
);
  localparam int LIMIT = PERIOD_CYC * MISS;
  localparam int TW    = $clog2(LIMIT + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          stale_q, stale_d, fire;

  always_comb begin
    fire = ~valid_i & ~inhibit_i & ~clr_i & (tmr_q == TW'(LIMIT - 1));

    tmr_d = tmr_q;
    if (valid_i || inhibit_i || clr_i)
      tmr_d = '0;
    else if (tmr_q != TW'(LIMIT))
      tmr_d = tmr_q + TW'(1);

    stale_d = stale_q;
    if (clr_i)
      stale_d = 1'b0;
    else if (fire)
      stale_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      tmr_q   <= tmr_d;
      stale_q <= stale_d;
    end
  end

  assign stale_d_o = stale_d;
  assign stale_q_o = stale_q;

  p_stale_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_q) |-> ($past(tmr_q) == TW'(LIMIT - 1)));

  p_sample_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (tmr_q == '0));
endmodule

// File: rtl/quench_persist_det.sv
module quench_persist_det
  import qpd_pkg::*;
#(
  parameter int SMP_W      = SMP_W_DEF,
  parameter int HOLD_W     = HOLD_W_DEF,
  parameter int MAX_HOLD   = MAX_HOLD_DEF,
  parameter int PERIOD_CYC = PERIOD_CYC_DEF,
  parameter int MISS       = MISS_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic        [SMP_W-1:0] thresh,
  input  logic       [HOLD_W-1:0] hold_len,
  input  logic                    inhibit,
  input  logic                    alarm_clr,
  output logic                    alarm_n
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       over;
  qpd_flag_t  flag_d, flag_q;
  logic       alarm_d, alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  qpd_mag_cmp #(.SMP_W(SMP_W)) u_cmp (
    .smp_i  (smp_data),
    .thr_i  (thresh),
    .over_o (over)
  );

  qpd_persist #(.HOLD_W(HOLD_W), .MAX_HOLD(MAX_HOLD)) u_run (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .valid_i    (smp_valid),
    .over_i     (over),
    .inhibit_i  (inhibit),
    .clr_i      (alarm_clr),
    .hold_len_i (hold_len),
    .quench_d_o (flag_d.quench),
    .quench_q_o (flag_q.quench)
  );

  qpd_stale_wd #(.PERIOD_CYC(PERIOD_CYC), .MISS(MISS)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .valid_i   (smp_valid),
    .inhibit_i (inhibit),
    .clr_i     (alarm_clr),
    .stale_d_o (flag_d.stale),
    .stale_q_o (flag_q.stale)
  );

  always_comb begin
    alarm_d = inhibit | ~(flag_d.quench | flag_d.stale);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)
      alarm_q <= 1'b1;
    else
      alarm_q <= alarm_d;
  end

  assign alarm_n = alarm_q;

  p_inhibit_high_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    inhibit |=> alarm_n);

  p_alarm_held_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!alarm_n && !alarm_clr && !inhibit) |=> !alarm_n);

  p_low_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !alarm_n |-> (flag_q.quench || flag_q.stale));
endmodule

// File: tb/sim_quench_persist_det.sv
module sim_quench_persist_det;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_valid;
  logic signed [15:0] smp_data;
  logic        [15:0] thresh;
  logic         [8:0] hold_len;
  logic               inhibit;
  logic               alarm_clr;
  logic               alarm_n;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   done     = 0;

  always #10 clk = ~clk;

  quench_persist_det #(.PERIOD_CYC(10)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thresh(thresh), .hold_len(hold_len), .inhibit(inhibit),
    .alarm_clr(alarm_clr), .alarm_n(alarm_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: alarm_n=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(alarm_n, it.exp, it.tag);
    end
  end

  task automatic step(input logic v, input logic signed [15:0] d,
                      input logic inh, input logic c,
                      input logic exp, input string tag);
    @(negedge clk);
    smp_valid = v; smp_data = d; inhibit = inh; alarm_clr = c;
    @(posedge clk);
    q.push_back('{exp, tag});
  endtask

  task automatic sample(input logic signed [15:0] d, input logic exp, input string tag);
    step(1'b1, d, 1'b0, 1'b0, exp, tag);
    for (int i = 0; i < 3; i++) step(1'b0, 16'sd0, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic clear_alarm(input string tag);
    step(1'b0, 16'sd0, 1'b0, 1'b1, 1'b1, tag);
    for (int i = 0; i < 3; i++) step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; inhibit = 1'b0;
    alarm_clr = 1'b0; thresh = 16'd100; hold_len = 9'd5;
    repeat (3) @(negedge clk);
    check(alarm_n, 1'b1, "R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(alarm_n, 1'b1, "R1 after release");

    // R2/R3: threshold-equal sample breaks the run
    for (int i = 0; i < 4; i++) sample(16'sd150, 1'b1, "R2 positive over");
    sample(16'sd100, 1'b1, "R3 equal to threshold clears");
    for (int i = 0; i < 4; i++) sample(-16'sd150, 1'b1, "R3 run restarted");
    sample(-16'sd150, 1'b0, "R4 fifth negative over trips");

    // R6 latching and clear
    sample(16'sd0, 1'b0, "R6 latched on quiet sample");
    clear_alarm("R6 clear releases");
    for (int i = 0; i < 4; i++) sample(16'sd150, 1'b1, "R6 build run");
    step(1'b1, 16'sd150, 1'b0, 1'b1, 1'b1, "R6 clear wins over trip");
    for (int i = 0; i < 3; i++) step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b1, "R6 after clear");
    for (int i = 0; i < 4; i++) sample(16'sd150, 1'b1, "R6 counter zeroed by clear");
    sample(16'sd150, 1'b0, "R4 trip after full run");
    clear_alarm("R6 clear");

    // R7 inhibit
    for (int i = 0; i < 4; i++) sample(16'sd150, 1'b1, "R7 build run");
    step(1'b1, 16'sd150, 1'b1, 1'b0, 1'b1, "R7 inhibit masks trip");
    for (int i = 0; i < 3; i++) step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b1, "R7 after inhibit");
    for (int i = 0; i < 4; i++) sample(16'sd150, 1'b1, "R7 counter zeroed by inhibit");
    sample(16'sd150, 1'b0, "R7 trip after inhibit");
    step(1'b0, 16'sd0, 1'b1, 1'b0, 1'b1, "R7 inhibit forces high");
    step(1'b0, 16'sd0, 1'b1, 1'b0, 1'b1, "R7 inhibit forces high");
    step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b0, "R7 latch retained");
    clear_alarm("R6 clear");

    // R5 holding time limits
    hold_len = 9'd0;
    sample(16'sd150, 1'b0, "R5 zero acts as one");
    clear_alarm("R6 clear");
    hold_len = 9'd400;
    for (int i = 0; i < 299; i++) sample(16'sd150, 1'b1, "R5 clamp not reached");
    sample(16'sd150, 1'b0, "R5 clamped to 300");
    clear_alarm("R6 clear");

    // R2 extremes
    hold_len = 9'd1; thresh = 16'h7FFF;
    sample(16'sd32767, 1'b1, "R2 equal to max threshold");
    sample(-16'sd32767, 1'b1, "R2 negative equal");
    sample(-16'sd32768, 1'b0, "R2 most negative exceeds");
    clear_alarm("R6 clear");
    thresh = 16'd100; hold_len = 9'd5;

    // R8 sample loss: valid edge + 29 quiet edges high, 30th low
    sample(16'sd10, 1'b1, "R8 fresh sample");
    for (int i = 0; i < 26; i++) step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b1, "R8 quiet");
    step(1'b0, 16'sd0, 1'b0, 1'b0, 1'b0, "R8 timeout at 30th edge");
    sample(16'sd10, 1'b0, "R8 stays latched");
    clear_alarm("R8 clear");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule